// File: doc/BRIEF.md
# Bit-Serial MAC Early-Termination Evaluator

This block runs the digital side of a bit-serial multiply-accumulate for a group of output channels. The input activations are applied one bit per iteration, starting at the most significant bit. Each iteration delivers one signed partial result per channel. The block shifts that value by the bit position and adds it to a running per-channel accumulator.

After each update, except the one for the last bit, the block reads two stored bounds for the channel: the largest and the smallest value that the still-missing partial results can add. It then applies two tests. The sign test stops a channel whose final value cannot be positive, and the channel's activation becomes zero. The magnitude test stops a channel whose remaining contribution is small next to its current accumulator, and the channel keeps that accumulator as its activation. A stopped channel is flagged on `term_o` so that upstream logic can skip it. A one-cycle `done_o` pulse follows once every channel has stopped.

The bound table has a write port that is loaded before a run. Its read for the next iteration is issued one cycle ahead, so iterations can arrive back to back.

Top module: `bsmac_eval`

## Requirements
- R1: After reset, `term_o`, `done_o` and every `act_o` lane read zero.
- R2: `start_i` is accepted only when no run is in progress. When accepted, it clears all terminate flags, accumulators and activations, and it captures `relu_en_i` and `thresh_i` for the run. A `start_i` raised while a run is in progress has no effect.
- R3: Iteration j (j = 0..ABITS-1) of a run uses bit position k = ABITS-1-j. For each channel that has not stopped, the signed partial on `part_i[ch*PR_W +: PR_W]` is shifted left by k and added to the channel's accumulator.
- R4: The bound table is written through `tbl_addr_i`. The channel number sits in the upper CH_W bits and the bit position k (1..ABITS-1) in the lower IT_W bits. The entry for k holds the signed maximum (`tbl_max_i`) and the signed minimum (`tbl_min_i`) of the sum of the partials for bits k-1 down to 0.
- R5: With ReLU captured as enabled and k ≥ 1, a channel whose updated accumulator plus its stored maximum is ≤ 0 stops, and its activation is 0. Equality to zero counts as a stop.
- R6: With ReLU captured as disabled, the sign test is never applied.
- R7: With k ≥ 1, a channel stops and outputs its updated accumulator unchanged when both |max|·256 ≤ T·|acc| and |min|·256 ≤ T·|acc|. Here T is the captured unsigned `thresh_i` with 8 fractional bits, and equality counts as a stop.
- R8: When the sign test and the magnitude test both hold, the sign test wins and the activation is 0.
- R9: At k = 0, every remaining channel stops with its exact accumulator. If ReLU is enabled, a negative value is replaced by 0.
- R10: A stopped channel keeps its flag and its activation unchanged through later iterations and after the run, until the next accepted start.
- R11: `done_o` is high for exactly one cycle, on the same clock edge at which the last remaining channel stops. That can be before all ABITS iterations. The block then returns to idle and ignores `part_valid_i`.
- R12: Results update on the clock edge that accepts `part_valid_i`. Cycles without `part_valid_i` change neither the flags nor the activations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (accepted when idle) |
| relu_en_i | input | 1 | Enable the sign test and final clamp for this run |
| thresh_i | input | T_W | Threshold T, unsigned, FRAC fractional bits |
| part_valid_i | input | 1 | One iteration's partials are present |
| part_i | input | NCH*PR_W | Signed partial result per channel |
| tbl_we_i | input | 1 | Bound table write enable |
| tbl_addr_i | input | CH_W+IT_W | {channel, bit position} write address |
| tbl_max_i | input | B_W | Signed bound on the remaining sum, upper |
| tbl_min_i | input | B_W | Signed bound on the remaining sum, lower |
| term_o | output | NCH | Per-channel stopped flag |
| act_o | output | NCH*ACC_W | Per-channel signed activation |
| done_o | output | 1 | One-cycle pulse when all channels have stopped |

## Verification
The bench targets the equality edges of both tests. An accumulator plus maximum of exactly zero must stop the channel, and a maximum one step larger must not. The same holds for bound magnitudes exactly equal to T·|acc|. An off-by-one comparator would miss these stops or stop too early. It also drives cases where both tests hold, where a design with the wrong priority would return the accumulator instead of zero. It feeds changing partials to channels that have already stopped, where a design that keeps accumulating would corrupt held activations. It checks that a run in which every channel stops on its first bit pulses `done_o` at once and then ignores further partials. Further runs raise `start_i` in the middle of a run and insert idle gaps between iterations, where a design that reloads its state or fails to hold its outputs would drift from the expected values.

// File: rtl/bsmac_pkg.sv
package bsmac_pkg;

    // controller phase
    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // per-channel verdict for one iteration
    typedef enum logic [1:0] {
        VD_GO     = 2'd0,   // keep accumulating
        VD_SIGN   = 2'd1,   // final value cannot be positive
        VD_APPROX = 2'd2,   // remaining work negligible
        VD_LAST   = 2'd3    // least significant bit processed
    } verdict_e;

endpackage

// File: rtl/bsmac_bound_tbl.sv
module bsmac_bound_tbl #(
    parameter int NCH  = 16,
    parameter int NIT  = 8,
    parameter int B_W  = 24,
    parameter int CH_W = 4,
    parameter int IT_W = 3
) (
    input  logic                         clk,
    input  logic                         we_i,
    input  logic [CH_W+IT_W-1:0]         waddr_i,
    input  logic [B_W-1:0]               wmax_i,
    input  logic [B_W-1:0]               wmin_i,
    input  logic [IT_W-1:0]              rd_it_i,
    output logic [NCH-1:0][B_W-1:0]      rd_max_o,
    output logic [NCH-1:0][B_W-1:0]      rd_min_o
);

    logic [CH_W-1:0] w_ch;
    logic [IT_W-1:0] w_it;

    assign w_ch = waddr_i[CH_W+IT_W-1:IT_W];
    assign w_it = waddr_i[IT_W-1:0];

    // one bank per channel so every channel reads its bounds in parallel
    for (genvar g = 0; g < NCH; g++) begin : g_bank
        logic [2*B_W-1:0] mem [NIT];
        logic             hit;

        assign hit = we_i && (w_ch == CH_W'(g)) && (int'(w_it) < NIT);

        always_ff @(posedge clk) begin
            if (hit) begin
                mem[w_it] <= {wmax_i, wmin_i};
            end
            rd_max_o[g] <= mem[rd_it_i][2*B_W-1:B_W];
            rd_min_o[g] <= mem[rd_it_i][B_W-1:0];
        end
    end

endmodule

// File: rtl/bsmac_chan_eval.sv
module bsmac_chan_eval
    import bsmac_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PR_W  = 16,
    parameter int B_W   = 24,
    parameter int T_W   = 12,
    parameter int FRAC  = 8,
    parameter int IT_W  = 3
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [PR_W-1:0]  part_i,
    input  logic [IT_W-1:0]  iter_i,
    input  logic             relu_en_i,
    input  logic [T_W-1:0]   thr_i,
    input  logic [B_W-1:0]   bmax_i,
    input  logic [B_W-1:0]   bmin_i,
    output logic [ACC_W-1:0] acc_o,
    output verdict_e         vd_o,
    output logic [ACC_W-1:0] res_o
);

    localparam int PROD_W = T_W + ACC_W;
    localparam int SCL_W  = B_W + FRAC;
    localparam int CMP_W  = (PROD_W > SCL_W) ? PROD_W : SCL_W;

    logic [ACC_W-1:0] wpart;
    logic [ACC_W-1:0] acc_n;
    logic [ACC_W:0]   probe;
    logic [ACC_W-1:0] acc_mag;
    logic [B_W-1:0]   max_mag;
    logic [B_W-1:0]   min_mag;
    logic [CMP_W-1:0] lim;
    logic [CMP_W-1:0] max_scl;
    logic [CMP_W-1:0] min_scl;
    logic             sign_hit;
    logic             apx_hit;

    always_comb begin
        // weight the partial by its bit position
        wpart = {{(ACC_W-PR_W){part_i[PR_W-1]}}, part_i} << iter_i;
        acc_n = acc_i + wpart;

        // sign test: one adder, one bit wider than the accumulator
        probe    = {acc_n[ACC_W-1], acc_n}
                 + {{(ACC_W+1-B_W){bmax_i[B_W-1]}}, bmax_i};
        sign_hit = relu_en_i && (probe[ACC_W] || (probe == '0));

        // magnitude test: full-width product against scaled bounds
        acc_mag = acc_n[ACC_W-1]  ? (~acc_n + 1'b1)  : acc_n;
        max_mag = bmax_i[B_W-1]   ? (~bmax_i + 1'b1) : bmax_i;
        min_mag = bmin_i[B_W-1]   ? (~bmin_i + 1'b1) : bmin_i;
        lim     = CMP_W'(thr_i) * CMP_W'(acc_mag);
        max_scl = CMP_W'({max_mag, {FRAC{1'b0}}});
        min_scl = CMP_W'({min_mag, {FRAC{1'b0}}});
        apx_hit = (max_scl <= lim) && (min_scl <= lim);

        acc_o = acc_n;
        res_o = acc_n;
        if (iter_i == '0) begin
            vd_o = VD_LAST;
            if (relu_en_i && acc_n[ACC_W-1]) begin
                res_o = '0;
            end
        end else if (sign_hit) begin
            vd_o  = VD_SIGN;
            res_o = '0;
        end else if (apx_hit) begin
            vd_o  = VD_APPROX;
        end else begin
            vd_o  = VD_GO;
        end
    end

endmodule

// File: rtl/bsmac_eval.sv
module bsmac_eval
    import bsmac_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int ABITS = 8,
    parameter int PR_W  = 16,
    parameter int ACC_W = 32,
    parameter int B_W   = 24,
    parameter int T_W   = 12,
    parameter int FRAC  = 8,
    parameter int CH_W  = $clog2(NCH),
    parameter int IT_W  = $clog2(ABITS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   relu_en_i,
    input  logic [T_W-1:0]         thresh_i,
    input  logic                   part_valid_i,
    input  logic [NCH*PR_W-1:0]    part_i,
    input  logic                   tbl_we_i,
    input  logic [CH_W+IT_W-1:0]   tbl_addr_i,
    input  logic [B_W-1:0]         tbl_max_i,
    input  logic [B_W-1:0]         tbl_min_i,
    output logic [NCH-1:0]         term_o,
    output logic [NCH*ACC_W-1:0]   act_o,
    output logic                   done_o
);

    localparam logic [IT_W-1:0] TOP_IT = IT_W'(ABITS - 1);

    typedef struct packed {
        phase_e                        phase;
        logic [IT_W-1:0]               iter;
        logic                          relu;
        logic [T_W-1:0]                thr;
        logic [NCH-1:0]                term;
        logic [NCH-1:0][ACC_W-1:0]     acc;
        logic [NCH-1:0][ACC_W-1:0]     act;
        logic                          done;
    } state_t;

    state_t s_q, s_d;

    logic [NCH-1:0][B_W-1:0]   bnd_max;
    logic [NCH-1:0][B_W-1:0]   bnd_min;
    logic [NCH-1:0][ACC_W-1:0] acc_nx;
    logic [NCH-1:0][ACC_W-1:0] res;
    verdict_e                  vd [NCH];
    logic                      busy;

    assign busy = (s_q.phase == PH_RUN);

    // read address follows the next iteration, so data is ready one cycle early
    bsmac_bound_tbl #(
        .NCH (NCH),
        .NIT (ABITS),
        .B_W (B_W),
        .CH_W(CH_W),
        .IT_W(IT_W)
    ) u_tbl (
        .clk     (clk),
        .we_i    (tbl_we_i),
        .waddr_i (tbl_addr_i),
        .wmax_i  (tbl_max_i),
        .wmin_i  (tbl_min_i),
        .rd_it_i (s_d.iter),
        .rd_max_o(bnd_max),
        .rd_min_o(bnd_min)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        bsmac_chan_eval #(
            .ACC_W(ACC_W),
            .PR_W (PR_W),
            .B_W  (B_W),
            .T_W  (T_W),
            .FRAC (FRAC),
            .IT_W (IT_W)
        ) u_eval (
            .acc_i    (s_q.acc[g]),
            .part_i   (part_i[g*PR_W +: PR_W]),
            .iter_i   (s_q.iter),
            .relu_en_i(s_q.relu),
            .thr_i    (s_q.thr),
            .bmax_i   (bnd_max[g]),
            .bmin_i   (bnd_min[g]),
            .acc_o    (acc_nx[g]),
            .vd_o     (vd[g]),
            .res_o    (res[g])
        );
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                s_d.iter = TOP_IT;
                if (start_i) begin
                    s_d.phase = PH_RUN;
                    s_d.relu  = relu_en_i;
                    s_d.thr   = thresh_i;
                    s_d.term  = '0;
                    s_d.acc   = '0;
                    s_d.act   = '0;
                end
            end
            PH_RUN: begin
                if (part_valid_i) begin
                    for (int c = 0; c < NCH; c++) begin
                        if (!s_q.term[c]) begin
                            s_d.acc[c] = acc_nx[c];
                            if (vd[c] != VD_GO) begin
                                s_d.term[c] = 1'b1;
                                s_d.act[c]  = res[c];
                            end
                        end
                    end
                    if (&s_d.term) begin
                        s_d.done  = 1'b1;
                        s_d.phase = PH_IDLE;
                        s_d.iter  = TOP_IT;
                    end else begin
                        s_d.iter  = s_q.iter - 1'b1;
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.iter <= TOP_IT;
        end else begin
            s_q      <= s_d;
        end
    end

    assign term_o = s_q.term;
    assign act_o  = s_q.act;
    assign done_o = s_q.done;

endmodule

// File: rtl/bsmac_eval_chk.sv
module bsmac_eval_chk #(
    parameter int NCH   = 16,
    parameter int ACC_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 part_valid_i,
    input logic                 busy,
    input logic [NCH-1:0]       term_o,
    input logic [NCH*ACC_W-1:0] act_o,
    input logic                 done_o
);

    // R2: an accepted start clears every flag
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> (term_o == '0));

    // R11: the pulse only comes with all channels stopped
    a_r11_done_all: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (&term_o));

    // R11: single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: back to idle with the pulse
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy);

    // R12: nothing moves without an iteration or a start
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!part_valid_i && !start_i) |=> ($stable(term_o) && $stable(act_o)));

    for (genvar g = 0; g < NCH; g++) begin : g_keep
        // R10: a stopped channel keeps its flag and value
        a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (term_o[g] && !(start_i && !busy))
            |=> (term_o[g] && $stable(act_o[g*ACC_W +: ACC_W])));
    end

endmodule

bind bsmac_eval bsmac_eval_chk #(
    .NCH  (NCH),
    .ACC_W(ACC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .part_valid_i(part_valid_i),
    .busy        (busy),
    .term_o      (term_o),
    .act_o       (act_o),
    .done_o      (done_o)
);

// File: tb/bsmac_eval_test.sv
`timescale 1ns/1ps
module bsmac_eval_test;

    localparam int NCH = 4;
    localparam int AB  = 4;
    localparam int PW  = 16;
    localparam int AW  = 32;
    localparam int BW  = 24;
    localparam int TW  = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             relu_en_i = 1'b0;
    logic [TW-1:0]    thresh_i = '0;
    logic             part_valid_i = 1'b0;
    logic [NCH*PW-1:0] part_i = '0;
    logic             tbl_we_i = 1'b0;
    logic [3:0]       tbl_addr_i = '0;
    logic [BW-1:0]    tbl_max_i = '0;
    logic [BW-1:0]    tbl_min_i = '0;
    logic [NCH-1:0]   term_o;
    logic [NCH*AW-1:0] act_o;
    logic             done_o;

    int n_run = 0;
    int n_bad = 0;

    longint pv  [AB][NCH];   // partial per bit position and channel
    longint bmx [NCH][AB];   // bound table contents
    longint bmn [NCH][AB];

    always #4 clk = ~clk;

    bsmac_eval #(
        .NCH(NCH), .ABITS(AB), .PR_W(PW), .ACC_W(AW),
        .B_W(BW), .T_W(TW), .FRAC(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .relu_en_i(relu_en_i),
        .thresh_i(thresh_i), .part_valid_i(part_valid_i), .part_i(part_i),
        .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_max_i(tbl_max_i),
        .tbl_min_i(tbl_min_i), .term_o(term_o), .act_o(act_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint lane(input int ch);
        return longint'($signed(act_o[ch*AW +: AW]));
    endfunction

    function automatic longint mag(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic set_loose();
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < AB; k++) begin
                bmx[c][k] = 1000000;
                bmn[c][k] = -1000000;
            end
        end
    endtask

    // R4: address is {channel, bit position}
    task automatic load_tbl();
        for (int c = 0; c < NCH; c++) begin
            for (int k = 1; k < AB; k++) begin
                @(negedge clk);
                tbl_we_i   = 1'b1;
                tbl_addr_i = {2'(c), 2'(k)};
                tbl_max_i  = BW'(bmx[c][k]);
                tbl_min_i  = BW'(bmn[c][k]);
            end
        end
        @(negedge clk);
        tbl_we_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic drive_parts(input int k);
        for (int c = 0; c < NCH; c++) part_i[c*PW +: PW] = PW'(pv[k][c]);
    endtask

    // run one MAC against a model built from the requirements
    task automatic run_mac(input string tag, input bit relu, input int thr,
                           input int gap, input bit poke);
        longint acc [NCH];
        longint act [NCH];
        bit     trm [NCH];
        bit     all;
        for (int c = 0; c < NCH; c++) begin
            acc[c] = 0; act[c] = 0; trm[c] = 1'b0;
        end
        load_tbl();
        @(negedge clk);
        start_i = 1'b1; relu_en_i = relu; thresh_i = TW'(thr);
        @(negedge clk);
        start_i = 1'b0;
        chk(term_o == '0, "R2", "flags after start", longint'(term_o), 0);
        for (int j = 0; j < AB; j++) begin
            int k = AB - 1 - j;
            for (int c = 0; c < NCH; c++) begin
                if (!trm[c]) begin
                    acc[c] += pv[k][c] * (longint'(1) << k);
                    if (k == 0) begin
                        trm[c] = 1'b1;
                        act[c] = (relu && acc[c] < 0) ? 0 : acc[c];
                    end else if (relu && (acc[c] + bmx[c][k] <= 0)) begin
                        trm[c] = 1'b1; act[c] = 0;
                    end else if (mag(bmx[c][k]) * 256 <= thr * mag(acc[c]) &&
                                 mag(bmn[c][k]) * 256 <= thr * mag(acc[c])) begin
                        trm[c] = 1'b1; act[c] = acc[c];
                    end
                end
            end
            drive_parts(k);
            part_valid_i = 1'b1;
            @(negedge clk);
            part_valid_i = 1'b0;
            all = 1'b1;
            for (int c = 0; c < NCH; c++) begin
                all &= trm[c];
                chk(term_o[c] == trm[c], tag, $sformatf("flag ch%0d bit%0d", c, k),
                    longint'(term_o[c]), longint'(trm[c]));
                chk(lane(c) == act[c], tag, $sformatf("act ch%0d bit%0d", c, k),
                    lane(c), act[c]);
            end
            chk(done_o == all, "R11", $sformatf("done at bit%0d", k),
                longint'(done_o), longint'(all));
            if (poke && j == 0) begin
                // R2: start while busy must be ignored
                start_i = 1'b1; relu_en_i = ~relu; thresh_i = 12'hfff;
                @(negedge clk);
                start_i = 1'b0;
            end
            for (int g = 0; g < gap; g++) begin
                part_i = '1;
                @(negedge clk);
                for (int c = 0; c < NCH; c++)
                    chk(lane(c) == act[c] && term_o[c] == trm[c], "R12",
                        $sformatf("idle hold ch%0d", c), lane(c), act[c]);
            end
            if (all) break;
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R11", "done falls", longint'(done_o), 0);
        // R10: partials after the run touch nothing
        part_i = {NCH{16'h1234}};
        part_valid_i = 1'b1;
        @(negedge clk);
        part_valid_i = 1'b0;
        @(negedge clk);
        for (int c = 0; c < NCH; c++)
            chk(lane(c) == act[c] && term_o[c], "R10",
                $sformatf("held ch%0d", c), lane(c), act[c]);
        chk(done_o == 1'b0, "R11", "no pulse when idle", longint'(done_o), 0);
    endtask

    task automatic set_parts(input longint a3[NCH], input longint a2[NCH],
                             input longint a1[NCH], input longint a0[NCH]);
        for (int c = 0; c < NCH; c++) begin
            pv[3][c] = a3[c]; pv[2][c] = a2[c]; pv[1][c] = a1[c]; pv[0][c] = a0[c];
        end
    endtask

    task automatic t_reset();
        chk(term_o == '0, "R1", "flags", longint'(term_o), 0);
        chk(done_o == 1'b0, "R1", "done", longint'(done_o), 0);
        for (int c = 0; c < NCH; c++)
            chk(lane(c) == 0, "R1", $sformatf("act ch%0d", c), lane(c), 0);
    endtask

    task automatic t_full();
        set_loose();
        set_parts('{1, -5, 100, 0}, '{2, 1, -3, 0}, '{3, 0, 7, 0}, '{4, 2, -1, 0});
        run_mac("R3/R4/R9", 1'b1, 0, 0, 1'b0);   // 26, clamp(-34)=0, 801, 0
        run_mac("R3/R9", 1'b0, 0, 0, 1'b0);      // 26, -34, 801, 0
    endtask

    task automatic t_relu_cut();
        set_loose();
        bmx[0][3] = 16;    // -16 + 16 = 0: stops
        bmx[1][3] = 17;    // -16 + 17 = 1: continues
        bmx[2][3] = 100;
        bmx[2][2] = 28;    // -28 + 28 at second bit
        set_parts('{-2, -2, -3, 5}, '{9, 1, -1, 1}, '{-7, 1, 2, 1}, '{3, 1, 1, 1});
        run_mac("R5", 1'b1, 0, 0, 1'b0);
        run_mac("R6", 1'b0, 0, 0, 1'b0);
    endtask

    task automatic t_approx(input int gap);
        set_loose();
        bmx[0][3] = 16;  bmn[0][3] = -16;   // 16*256 == 128*32: stops
        bmx[1][3] = 17;  bmn[1][3] = -3;    // one over: continues
        bmx[2][3] = 16;  bmn[2][3] = -16;   // negative accumulator: stops
        bmx[3][3] = 16;  bmn[3][3] = -17;   // minimum one over
        set_parts('{4, 4, -4, 4}, '{-9, 1, 9, 2}, '{5, 1, 5, 3}, '{6, 1, 6, 4});
        run_mac(gap > 0 ? "R7/R12" : "R7", 1'b0, 128, gap, 1'b0);
    endtask

    task automatic t_prio();
        set_loose();
        bmx[0][3] = 16; bmn[0][3] = -16;    // both tests hold
        set_parts('{-2, 3, 1, 2}, '{5, 1, 1, 1}, '{5, 1, 1, 1}, '{5, 1, 1, 1});
        run_mac("R8", 1'b1, 256, 0, 1'b0);
    endtask

    task automatic t_early_done();
        set_loose();
        for (int c = 0; c < NCH; c++) bmx[c][3] = 8;
        set_parts('{-1, -1, -1, -1}, '{7, 7, 7, 7}, '{7, 7, 7, 7}, '{7, 7, 7, 7});
        run_mac("R11/R10", 1'b1, 0, 0, 1'b0);
    endtask

    task automatic t_busy_start();
        set_loose();
        set_parts('{3, -2, 1, 0}, '{-1, 2, 2, 1}, '{1, -1, 3, 0}, '{1, 1, -4, 2});
        run_mac("R2", 1'b0, 0, 0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_full();
        t_relu_cut();
        t_approx(0);
        t_approx(3);
        t_prio();
        t_early_done();
        t_busy_start();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule